// File: doc/BRIEF.md
# Incrementing-Burst Bus Master with Pause Cycles

This block is a bus master for a single-master AHB-Lite segment. A command supplies a start address, a direction and a beat count. The master then runs an incrementing burst of word transfers. The first beat is marked NONSEQ and each later beat is marked SEQ. Each address is one transfer size above the one before it.

A user-side `user_hold` input lets the local logic pause address issue in the middle of a burst. While it is high, the master puts BUSY cycles on the bus, and these already show the address of the beat still to come. The bus stays pipelined throughout. The data phase of a beat that was already accepted completes in the cycle after its address phase, whether or not the master is pausing, and only the slave's HREADY can stretch it. The master hands each read word to a result port. It takes each write word from a local buffer, which it indexes by beat number.

An error response ends the burst early. The master cancels the next address phase during the first cycle of the error response. It then reports the error together with the done pulse.

Top module: `ahb_burst_master`

## Requirements
- R1: After reset, `htrans` is IDLE (2'b00), `done`, `err` and `rd_valid` are low, and `cmd_ready` equals `hready`.
- R2: An accepted command puts NONSEQ (2'b10) on the bus at `cmd_addr`, with `hwrite`=`cmd_write`, `hsize`=3'b010 and `hburst`=3'b001. Beats 1 to `cmd_len` follow as SEQ (2'b11). Each SEQ address is 4 above the previous beat's address.
- R3: Suppose `user_hold` is high at a rising edge where `hready` is high and beats remain to be issued. The next address phase is then BUSY (2'b01) at the address of the next beat. The burst later resumes with SEQ at that same address, never with NONSEQ.
- R4: While `hready` is low and `hresp` is low, `htrans`, `haddr` and `hwrite` do not change.
- R5: A read beat completes at a rising edge where `hready` is high and `hresp` is low. At that edge its `hrdata` is captured, and in the following cycle `rd_valid` is high with `rd_idx` set to the beat index. This holds even when that edge falls inside BUSY cycles.
- R6: Throughout a write beat's data phase, `wr_idx` shows that beat's index and `hwdata` equals `wr_data`.
- R7: `done` pulses for one cycle after the edge at which the final beat's data phase completes. `cmd_ready` returns once the bus is idle and `hready` is high.
- R8: If `hresp` is high while `hready` is low during a data phase, the next address phase is IDLE and no further beat is issued. When that data phase completes, `done` and `err` pulse together, and that beat gives no `rd_valid`.
- R9: A burst of `cmd_len`+1 beats produces exactly `cmd_len`+1 accepted NONSEQ/SEQ address phases and, for reads, exactly that many `rd_valid` pulses. BUSY and IDLE cycles produce no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a burst |
| cmd_ready | output | 1 | Master idle and able to start a burst this cycle |
| cmd_write | input | 1 | 1 = write burst |
| cmd_addr | input | ADDR_W | Start address |
| cmd_len | input | LEN_W | Beat count minus one |
| user_hold | input | 1 | Pause address issue (BUSY) |
| wr_idx | output | LEN_W | Beat index of the current write data phase |
| wr_data | input | DATA_W | Write word for beat `wr_idx` |
| rd_valid | output | 1 | Read word available |
| rd_idx | output | LEN_W | Beat index of the read word |
| rd_data | output | DATA_W | Read word |
| done | output | 1 | Burst finished |
| err | output | 1 | Burst ended with an error response |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type (incrementing) |
| hwdata | output | DATA_W | Write data |
| hready | input | 1 | Slave ready / transfer done |
| hresp | input | 1 | Slave error response |
| hrdata | input | DATA_W | Read data |

## Verification
Suppose the beat counter or the next-address register goes wrong. The bus then shows the wrong address or transfer type in the very next address phase, or one beat too many or too few before `done`. A data-phase record that is lost or doubled shows within one cycle as a missing or extra `rd_valid`, a wrong `rd_idx`, or a wrong write word landing in the slave. A bad hold decision would let the address outputs move while `hready` is low, or would re-issue NONSEQ after a pause, and either shows in the same cycle.

// File: rtl/ahb_burst_master.sv
module ahb_burst_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              user_hold,
  output logic [LEN_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [LEN_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic              hresp,
  input  logic [DATA_W-1:0] hrdata
);
  localparam int BYTES = DATA_W / 8;
  localparam logic [2:0] SIZE = 3'($clog2(BYTES));
  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

  logic              active, dp_valid, dp_write;
  logic [LEN_W-1:0]  last, dp_idx;
  logic [LEN_W:0]    iss;

  wire             acc     = hready && htrans[1];
  wire [LEN_W:0]   iss_n   = iss + (LEN_W+1)'(acc);
  wire             more    = iss_n <= {1'b0, last};
  wire             dp_done = dp_valid && hready;
  wire             dp_err  = dp_valid && hresp;
  wire             fin     = dp_idx == last;

  assign cmd_ready = !active && !dp_valid && hready;
  assign hsize     = SIZE;
  assign hburst    = 3'b001;
  assign wr_idx    = dp_idx;
  assign hwdata    = (dp_valid && dp_write) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; htrans <= T_IDLE; haddr <= '0; hwrite <= 1'b0;
      last <= '0; iss <= '0;
      dp_valid <= 1'b0; dp_write <= 1'b0; dp_idx <= '0;
    end else if (dp_err && !hready) begin
      htrans <= T_IDLE;
      active <= 1'b0;
    end else if (hready) begin
      dp_valid <= acc;
      dp_write <= hwrite;
      dp_idx   <= iss[LEN_W-1:0];
      if (acc) begin
        iss   <= iss_n;
        haddr <= haddr + ADDR_W'(BYTES);
      end
      if (dp_err) begin
        htrans <= T_IDLE;
        active <= 1'b0;
      end else if (active && more) begin
        htrans <= user_hold ? T_BUSY : T_SEQ;
      end else if (active) begin
        htrans <= T_IDLE;
        if (dp_done && fin) active <= 1'b0;
      end else if (cmd_valid && !dp_valid) begin
        active <= 1'b1;
        htrans <= T_NSEQ;
        haddr  <= cmd_addr;
        hwrite <= cmd_write;
        last   <= cmd_len;
        iss    <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_idx <= '0; rd_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      rd_valid <= dp_done && !dp_write && !hresp;
      rd_idx   <= dp_idx;
      if (dp_done) rd_data <= hrdata;
      done     <= dp_done && (hresp || fin);
      err      <= dp_done && hresp;
    end
  end
endmodule

// File: rtl/ahb_burst_master_chk.sv
module ahb_burst_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic              hready,
  input logic              hresp
);
  localparam int BYTES = DATA_W / 8;

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && !hresp) |=> ($stable(htrans) && $stable(haddr) && $stable(hwrite)))
    else $error("p_hold_stable_r4");

  p_busy_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b01 && hready && !hresp) |=> (haddr == $past(haddr) && htrans != 2'b10))
    else $error("p_busy_addr_r3");

  p_seq_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans[1] && hready && !hresp) |=>
      (!(htrans == 2'b11 || htrans == 2'b01) || haddr == $past(haddr) + ADDR_W'(BYTES)))
    else $error("p_seq_incr_r2");

  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done)
    else $error("p_err_done_r8");

  p_err_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hready) |=> htrans == 2'b00)
    else $error("p_err_cancel_r8");

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> htrans == 2'b00)
    else $error("p_ready_idle_r7");
endmodule

bind ahb_burst_master ahb_burst_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .err(err),
  .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hready(hready), .hresp(hresp)
);

// File: tb/ahb_burst_master_tb_top.sv
module ahb_burst_master_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 32, DW = 32, LW = 4;

  logic clk = 0, rst_n = 0;
  always #(CLK_P/2) clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic cmd_ready, user_hold, rd_valid, done, err, hwrite, hready, hresp;
  logic [LW-1:0] wr_idx, rd_idx;
  logic [DW-1:0] wr_data, rd_data, hwdata, hrdata;
  logic [AW-1:0] haddr;
  logic [1:0] htrans;
  logic [2:0] hsize, hburst;

  int tests = 0, fails = 0, mtests = 0, mfails = 0;
  int wmode = 0, hmode = 0, err_beat = -1, run_id = 0;
  bit err_en = 0, clr = 0, exp_w = 0;
  logic [AW-1:0] base = '0;
  logic [31:0] cyc = '0;

  logic pend_v = 0, pend_w = 0, err_ph = 0;
  logic [AW-1:0] pend_a = '0;
  int pend_i = 0, acc_cnt = 0;
  logic [DW-1:0] mem [64];

  function automatic logic [DW-1:0] rfun(logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic logic [DW-1:0] wfun(int r, int i);
    return {16'(r), 12'h5A0, 4'(i)};
  endfunction

  wire err_act = err_en && pend_v && pend_i == err_beat;
  assign hready    = err_act ? err_ph : (wmode == 0 ? 1'b1 : (cyc % (wmode + 1)) == wmode);
  assign hresp     = err_act;
  assign user_hold = hmode != 0 && (cyc % 4) < hmode;
  assign hrdata    = (pend_v && !pend_w) ? rfun(pend_a) : '0;
  assign wr_data   = wfun(run_id, int'(wr_idx));

  ahb_burst_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .user_hold(user_hold),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_valid(rd_valid), .rd_idx(rd_idx),
    .rd_data(rd_data), .done(done), .err(err), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hrdata(hrdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || clr) begin
      pend_v <= 0; acc_cnt <= 0; err_ph <= 0;
    end else begin
      err_ph <= err_act && !hready;
      if (hready) begin
        if (pend_v && pend_w) mem[pend_a[7:2]] <= hwdata;
        pend_v <= htrans[1];
        pend_w <= hwrite;
        pend_a <= haddr;
        pend_i <= acc_cnt;
        if (htrans[1]) acc_cnt <= acc_cnt + 1;
      end
    end
  end

  int rd_cnt = 0, done_cnt = 0, busy_cnt = 0;
  bit last_err = 0, pv = 0, p_hr = 0, p_rs = 0;
  logic [1:0] p_t = '0;
  logic [AW-1:0] p_a = '0;

  task automatic mchk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    mtests++;
    if (!ok) begin
      mfails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (clr) begin
      rd_cnt = 0; busy_cnt = 0; pv = 0;
    end else if (rst_n) begin
      if (rd_valid) begin
        mchk(rd_idx == LW'(rd_cnt), "R5 rd_idx", 64'(rd_idx), 64'(rd_cnt));
        mchk(rd_data == rfun(base + AW'(4 * int'(rd_idx))), "R5 rd_data",
             64'(rd_data), 64'(rfun(base + AW'(4 * int'(rd_idx)))));
        rd_cnt++;
      end
      if (done) begin
        done_cnt++;
        last_err = err;
      end
      if (htrans == 2'b11 || htrans == 2'b01) begin
        mchk(haddr == base + AW'(4 * acc_cnt), "R2/R3 beat address", 64'(haddr),
             64'(base + AW'(4 * acc_cnt)));
        if (htrans == 2'b01) busy_cnt++;
      end
      if (htrans == 2'b10)
        mchk(haddr == base && hwrite == exp_w && hsize == 3'b010 && hburst == 3'b001 && acc_cnt == 0,
             "R2 first beat", 64'(haddr), 64'(base));
      if (pend_v && pend_w) begin
        mchk(wr_idx == LW'(pend_i), "R6 wr_idx", 64'(wr_idx), 64'(pend_i));
        mchk(hwdata == wfun(run_id, pend_i), "R6 hwdata", 64'(hwdata), 64'(wfun(run_id, pend_i)));
      end
      if (pv && !p_hr && !p_rs)
        mchk(htrans == p_t && haddr == p_a, "R4 held during wait", 64'(haddr), 64'(p_a));
      if (pv && p_hr && p_t == 2'b01)
        mchk(htrans != 2'b10, "R3 no NONSEQ after BUSY", 64'(htrans), 64'(2'b11));
      pv = 1; p_hr = hready; p_rs = hresp; p_t = htrans; p_a = haddr;
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(bit w, int len, int wm, int hm, int eb);
    int d0, n_ok, seen;
    run_id++;
    wmode = wm; hmode = hm; err_en = eb >= 0; err_beat = eb;
    base = 32'h2000 + AW'(4 * (run_id % 8)); exp_w = w;
    @(posedge clk); #1 clr = 1;
    @(posedge clk); #1 clr = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = w; cmd_addr = base; cmd_len = LW'(len - 1);
    @(negedge clk); cmd_valid = 0;
    d0 = done_cnt; seen = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(posedge clk); #1;
      if (done_cnt != d0) seen = 1;
    end
    chk(seen == 1, "R7 done pulse", 64'(seen), 64'(1));
    chk(last_err == (eb >= 0), "R8 err flag", 64'(last_err), 64'(eb >= 0));
    n_ok = (eb >= 0) ? eb : len;
    chk(acc_cnt == ((eb >= 0) ? eb + 1 : len), "R9/R8 accepted beats", 64'(acc_cnt),
        64'((eb >= 0) ? eb + 1 : len));
    if (!w) chk(rd_cnt == n_ok, "R9 rd_valid count", 64'(rd_cnt), 64'(n_ok));
    else for (int i = 0; i < n_ok; i++)
      chk(mem[6'((base[7:2]) + 6'(i))] == wfun(run_id, i), "R6 written word",
          64'(mem[6'((base[7:2]) + 6'(i))]), 64'(wfun(run_id, i)));
    if (hm == 2 && wm == 0 && len >= 4 && eb < 0)
      chk(busy_cnt > 0, "R3 BUSY inserted", 64'(busy_cnt), 64'(1));
    seen = 0;
    for (int k = 0; k < 6 && !seen; k++) begin
      @(negedge clk);
      if (cmd_ready) seen = 1;
    end
    chk(seen == 1, "R7 ready after done", 64'(seen), 64'(1));
  endtask

  initial begin
    #(CLK_P * 150000);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests + mtests + 1, fails + mfails + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(htrans == 2'b00, "R1 htrans idle", 64'(htrans), 64'(0));
    chk(cmd_ready == hready, "R1 cmd_ready", 64'(cmd_ready), 64'(hready));
    chk(!done && !err && !rd_valid, "R1 outputs low", 64'({done, err, rd_valid}), 64'(0));
    for (int w = 0; w < 2; w++)
      for (int len = 1; len <= 6; len++)
        for (int wm = 0; wm < 3; wm++)
          for (int hm = 0; hm < 3; hm++)
            run(w[0], len, wm, hm, -1);
    for (int w = 0; w < 2; w++)
      for (int eb = 0; eb < 4; eb++)
        run(w[0], 4, 0, 0, eb);
    repeat (4) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests + mtests, fails + mfails);
    $finish;
  end
endmodule